// File: doc/BRIEF.md
# I2C Message Stream Target

This block is a target-only I2C port that lets a host exchange byte streams with the rest of the chip. The host drains a transmit queue by reading one streaming register. It reads the number of bytes waiting from a pair of count registers. It pushes message bytes toward a receive queue by writing. The port never drives SCL. It pulls SDA low through an open-drain enable. It answers only when the 7-bit address matches a configuration byte.

The port shows 256 one-byte register addresses, and an internal pointer selects among them. A read always starts at the pointer. After each byte the pointer steps up by one, but it stays put once it reaches the top address. The pointer starts at the top address, so a plain read with no register address streams queue bytes from the first access. A write that carries exactly one byte sets the pointer. A write that carries two or more bytes is message data.

Both line inputs pass through a short synchronizer and are edge-detected in the system clock. That clock must run at least ten times faster than SCL, which may go up to 400 kHz. The queues sit outside the block. The transmit side offers its head byte, an empty flag and a fill count, and takes a one-cycle pop pulse. The receive side takes a byte with a one-cycle push pulse.

Top module: `i2c_stream_target`

## Requirements
- R1: After reset SDA is released (`sda_oe_o` = 0), no pop or push pulse is issued, and the pointer is 0xFF, so a read with no register address returns queue data, or 0xFF when the queue is empty.
- R2: The port acknowledges an address byte only when its upper seven bits equal `dev_addr_cfg_i[7:1]`; `dev_addr_cfg_i[0]` is ignored. On a mismatch SDA stays released and the rest of the transfer has no effect until the next START.
- R3: Reading address 0xFF returns the head byte `tx_data_i` and issues exactly one single-cycle `tx_pop_o` pulse. When `tx_empty_i` is 1 it returns 0xFF and issues no pop.
- R4: Reading any address from 0x00 to 0xFC returns 0x00 and has no side effect on the transmit queue.
- R5: Reading 0xFD returns `tx_count_i[15:8]` and captures `tx_count_i[7:0]` at the same moment. Reading 0xFE returns that captured low byte, even if the count has changed since.
- R6: The pointer steps up by one after each byte read, and saturates at 0xFF.
- R7: A write transfer that ends after exactly one data byte, by STOP or by repeated START, loads that byte into the pointer. A following read then starts at that address.
- R8: A write transfer of two or more data bytes pushes every byte in order, each as a one-cycle `rx_push_o` pulse with the byte on `rx_data_o`. Every byte is acknowledged, and the pointer does not change.
- R9: Read bytes are sent most significant bit first. `sda_oe_o` changes only while SCL is low. A NACK from the host ends the read with no further fetch, so no extra pop occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 10x SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as sensed |
| sda_i | input | 1 | Bus data line as sensed |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| dev_addr_cfg_i | input | 8 | Target address in bits 7:1; bit 0 unused |
| tx_count_i | input | 16 | Bytes waiting in the transmit queue |
| tx_empty_i | input | 1 | Transmit queue has no byte |
| tx_data_i | input | 8 | Head byte of the transmit queue |
| tx_pop_o | output | 1 | One-cycle pulse removing the head byte |
| rx_data_o | output | 8 | Byte offered to the receive queue |
| rx_push_o | output | 1 | One-cycle pulse, `rx_data_o` valid |

## Verification
The assertions assume that the host follows the bus rules. It changes SDA only while SCL is low, except at START and STOP. Every SCL phase lasts many system clocks, so an output change made after a detected falling edge settles while SCL is still low. The assertions also assume that the transmit queue keeps its empty flag steady between a fetch and its pop. The bench meets these assumptions with a host model that always changes SDA a quarter period after SCL falls, using an SCL period of 40 system clocks. Its queue model removes the head byte only on a pop.

// File: rtl/i2c_stream_pkg.sv
package i2c_stream_pkg;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned PTR_W   = 8;
    localparam int unsigned BITS_W  = $clog2(BYTE_W + 1);

    localparam logic [PTR_W-1:0] PTR_TOP    = {PTR_W{1'b1}};
    localparam logic [PTR_W-1:0] PTR_CNT_HI = PTR_TOP - 2;
    localparam logic [PTR_W-1:0] PTR_CNT_LO = PTR_TOP - 1;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_ADDR,
        PH_ADDR_ACK,
        PH_WR_BYTE,
        PH_WR_ACK,
        PH_RD_BYTE,
        PH_RD_ACK
    } phase_e;

    typedef enum logic [1:0] {
        WR_NONE,
        WR_ONE,
        WR_MANY
    } wr_fill_e;

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
    parameter int unsigned STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic sda_o,
    output logic start_o,
    output logic stop_o
);

    logic [STAGES-1:0] scl_pipe_q, scl_pipe_d;
    logic [STAGES-1:0] sda_pipe_q, sda_pipe_d;
    logic              scl_prev_q, sda_prev_q;
    logic              scl_s, sda_s;

    assign scl_s = scl_pipe_q[STAGES-1];
    assign sda_s = sda_pipe_q[STAGES-1];

    always_comb begin
        scl_pipe_d = {scl_pipe_q[STAGES-2:0], scl_i};
        sda_pipe_d = {sda_pipe_q[STAGES-2:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_pipe_q <= '1;
            sda_pipe_q <= '1;
            scl_prev_q <= 1'b1;
            sda_prev_q <= 1'b1;
        end else begin
            scl_pipe_q <= scl_pipe_d;
            sda_pipe_q <= sda_pipe_d;
            scl_prev_q <= scl_s;
            sda_prev_q <= sda_s;
        end
    end

    assign scl_rise_o = scl_s & ~scl_prev_q;
    assign scl_fall_o = ~scl_s & scl_prev_q;
    assign sda_o      = sda_s;
    // data line moving while the clock line stays high
    assign start_o    = scl_s & scl_prev_q & sda_prev_q & ~sda_s;
    assign stop_o     = scl_s & scl_prev_q & ~sda_prev_q & sda_s;

endmodule

// File: rtl/i2c_reg_fetch.sv
module i2c_reg_fetch
    import i2c_stream_pkg::*;
#(
    parameter logic [BYTE_W-1:0] RSVD_VALUE  = 8'h00,
    parameter logic [BYTE_W-1:0] EMPTY_VALUE = 8'hFF
) (
    input  logic [PTR_W-1:0]    ptr_i,
    input  logic [15:0]         count_i,
    input  logic                empty_i,
    input  logic [BYTE_W-1:0]   head_i,
    input  logic [BYTE_W-1:0]   snap_i,
    output logic [BYTE_W-1:0]   data_o,
    output logic                pop_o,
    output logic                capture_o,
    output logic [BYTE_W-1:0]   snap_o,
    output logic [PTR_W-1:0]    ptr_next_o
);

    always_comb begin
        data_o    = RSVD_VALUE;
        pop_o     = 1'b0;
        capture_o = 1'b0;
        snap_o    = count_i[7:0];
        if (ptr_i == PTR_TOP) begin
            data_o = empty_i ? EMPTY_VALUE : head_i;
            pop_o  = ~empty_i;
        end else if (ptr_i == PTR_CNT_HI) begin
            data_o    = count_i[15:8];
            capture_o = 1'b1;
        end else if (ptr_i == PTR_CNT_LO) begin
            data_o = snap_i;
        end
        ptr_next_o = (ptr_i == PTR_TOP) ? PTR_TOP : ptr_i + 1'b1;
    end

endmodule

// File: rtl/i2c_stream_target.sv
module i2c_stream_target
    import i2c_stream_pkg::*;
#(
    parameter int unsigned       SYNC_STAGES = 2,
    parameter int unsigned       CNT_W       = 16,
    parameter logic [BYTE_W-1:0] RSVD_VALUE  = 8'h00,
    parameter logic [BYTE_W-1:0] EMPTY_VALUE = 8'hFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [7:0]        dev_addr_cfg_i,
    input  logic [CNT_W-1:0]  tx_count_i,
    input  logic              tx_empty_i,
    input  logic [BYTE_W-1:0] tx_data_i,
    output logic              tx_pop_o,
    output logic [BYTE_W-1:0] rx_data_o,
    output logic              rx_push_o
);

    typedef struct packed {
        phase_e              ph;
        logic [BITS_W-1:0]   bits;
        logic [BYTE_W-1:0]   sh;
        logic                rw;
        logic                drive;
        logic [PTR_W-1:0]    ptr;
        logic [BYTE_W-1:0]   held;
        wr_fill_e            fill;
        logic [BYTE_W-1:0]   snap;
        logic                mnack;
        logic                push;
        logic [BYTE_W-1:0]   push_data;
        logic                pop;
    } ctl_t;

    localparam logic [BITS_W-1:0] BITS_FULL = BITS_W'(BYTE_W);

    ctl_t ctl_d, ctl_q;

    logic scl_rise, scl_fall, sda_s, start_w, stop_w;
    logic [15:0]       cnt_w;
    logic [BYTE_W-1:0] f_data, f_snap;
    logic              f_pop, f_cap, fetch;
    logic [PTR_W-1:0]  f_ptr_next;
    logic              addr_hit;

    assign cnt_w = 16'(tx_count_i);

    i2c_line_sync #(.STAGES(SYNC_STAGES)) i_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .sda_o      (sda_s),
        .start_o    (start_w),
        .stop_o     (stop_w)
    );

    i2c_reg_fetch #(.RSVD_VALUE(RSVD_VALUE), .EMPTY_VALUE(EMPTY_VALUE)) i_fetch (
        .ptr_i      (ctl_q.ptr),
        .count_i    (cnt_w),
        .empty_i    (tx_empty_i),
        .head_i     (tx_data_i),
        .snap_i     (ctl_q.snap),
        .data_o     (f_data),
        .pop_o      (f_pop),
        .capture_o  (f_cap),
        .snap_o     (f_snap),
        .ptr_next_o (f_ptr_next)
    );

    // the direction bit is masked out of the compare
    assign addr_hit = ((ctl_q.sh ^ dev_addr_cfg_i) & 8'hFE) == 8'h00;

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.push = 1'b0;
        ctl_d.pop  = 1'b0;
        fetch      = 1'b0;

        if (start_w || stop_w) begin
            // a finished write decides here between pointer load and data
            if (ctl_q.ph == PH_WR_BYTE || ctl_q.ph == PH_WR_ACK) begin
                if (ctl_q.fill == WR_ONE) begin
                    ctl_d.ptr = ctl_q.held;
                end else if (ctl_q.fill == WR_MANY) begin
                    ctl_d.push      = 1'b1;
                    ctl_d.push_data = ctl_q.held;
                end
            end
            ctl_d.fill  = WR_NONE;
            ctl_d.drive = 1'b0;
            ctl_d.bits  = '0;
            ctl_d.ph    = start_w ? PH_ADDR : PH_IDLE;
        end else begin
            unique case (ctl_q.ph)
                PH_IDLE: begin
                    ctl_d.drive = 1'b0;
                end
                PH_ADDR: begin
                    if (scl_rise && ctl_q.bits != BITS_FULL) begin
                        ctl_d.sh   = {ctl_q.sh[BYTE_W-2:0], sda_s};
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end else if (scl_fall && ctl_q.bits == BITS_FULL) begin
                        if (addr_hit) begin
                            ctl_d.ph    = PH_ADDR_ACK;
                            ctl_d.rw    = ctl_q.sh[0];
                            ctl_d.drive = 1'b1;
                        end else begin
                            ctl_d.ph = PH_IDLE;
                        end
                    end
                end
                PH_ADDR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.bits = '0;
                        if (ctl_q.rw) begin
                            fetch    = 1'b1;
                            ctl_d.ph = PH_RD_BYTE;
                        end else begin
                            ctl_d.drive = 1'b0;
                            ctl_d.fill  = WR_NONE;
                            ctl_d.ph    = PH_WR_BYTE;
                        end
                    end
                end
                PH_WR_BYTE: begin
                    if (scl_rise && ctl_q.bits != BITS_FULL) begin
                        ctl_d.sh   = {ctl_q.sh[BYTE_W-2:0], sda_s};
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end else if (scl_fall && ctl_q.bits == BITS_FULL) begin
                        ctl_d.drive = 1'b1;
                        ctl_d.ph    = PH_WR_ACK;
                        ctl_d.held  = ctl_q.sh;
                        if (ctl_q.fill == WR_NONE) begin
                            ctl_d.fill = WR_ONE;
                        end else begin
                            ctl_d.push      = 1'b1;
                            ctl_d.push_data = ctl_q.held;
                            ctl_d.fill      = WR_MANY;
                        end
                    end
                end
                PH_WR_ACK: begin
                    if (scl_fall) begin
                        ctl_d.drive = 1'b0;
                        ctl_d.bits  = '0;
                        ctl_d.ph    = PH_WR_BYTE;
                    end
                end
                PH_RD_BYTE: begin
                    if (scl_rise && ctl_q.bits != BITS_FULL) begin
                        ctl_d.bits = ctl_q.bits + 1'b1;
                    end else if (scl_fall) begin
                        if (ctl_q.bits == BITS_FULL) begin
                            ctl_d.drive = 1'b0;
                            ctl_d.ph    = PH_RD_ACK;
                        end else begin
                            ctl_d.sh    = {ctl_q.sh[BYTE_W-2:0], 1'b0};
                            ctl_d.drive = ~ctl_q.sh[BYTE_W-2];
                        end
                    end
                end
                PH_RD_ACK: begin
                    if (scl_rise) begin
                        ctl_d.mnack = sda_s;
                    end else if (scl_fall) begin
                        if (ctl_q.mnack) begin
                            ctl_d.ph = PH_IDLE;
                        end else begin
                            fetch      = 1'b1;
                            ctl_d.bits = '0;
                            ctl_d.ph   = PH_RD_BYTE;
                        end
                    end
                end
                default: begin
                    ctl_d.ph    = PH_IDLE;
                    ctl_d.drive = 1'b0;
                end
            endcase
        end

        if (fetch) begin
            ctl_d.sh    = f_data;
            ctl_d.drive = ~f_data[BYTE_W-1];
            ctl_d.pop   = f_pop;
            ctl_d.ptr   = f_ptr_next;
            if (f_cap) begin
                ctl_d.snap = f_snap;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q           <= '0;
            ctl_q.ph        <= PH_IDLE;
            ctl_q.fill      <= WR_NONE;
            ctl_q.ptr       <= PTR_TOP;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign sda_oe_o  = ctl_q.drive;
    assign tx_pop_o  = ctl_q.pop;
    assign rx_push_o = ctl_q.push;
    assign rx_data_o = ctl_q.push_data;

endmodule

// File: rtl/i2c_stream_target_chk.sv
module i2c_stream_target_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe_o,
    input logic tx_empty_i,
    input logic tx_pop_o,
    input logic rx_push_o
);

    // R3: a pop is only issued against a queue that holds a byte
    p_pop_has_data_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |-> !tx_empty_i);

    // R3: one fetch gives one pop pulse
    p_pop_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop_o |=> !tx_pop_o);

    // R8: every pushed byte is a single-cycle pulse
    p_push_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push_o |=> !rx_push_o);

    // R9: the data line drive holds while the clock line is high
    p_sda_quiet_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_i && $past(scl_i)) |-> $stable(sda_oe_o));

endmodule

bind i2c_stream_target i2c_stream_target_chk i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .scl_i      (scl_i),
    .sda_oe_o   (sda_oe_o),
    .tx_empty_i (tx_empty_i),
    .tx_pop_o   (tx_pop_o),
    .rx_push_o  (rx_push_o)
);

// File: tb/test_i2c_stream_target.sv
`timescale 1ns/1ps
module test_i2c_stream_target;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic        scl_m = 1'b1;
    logic        sda_m = 1'b1;
    logic        sda_line;
    logic        sda_oe_o;
    logic [7:0]  dev_cfg = 8'h86;
    logic [6:0]  dev7 = 7'h43;
    logic [15:0] tx_count_i;
    logic        tx_empty_i;
    logic [7:0]  tx_data_i;
    logic        tx_pop_o;
    logic [7:0]  rx_data_o;
    logic        rx_push_o;

    logic [7:0]  txq [0:63];
    int          tx_head = 0;
    int          tx_tail = 0;
    logic [15:0] bias = 16'h0000;
    logic [7:0]  rxq [0:63];
    int          rx_n = 0;

    int nchk = 0;
    int nerr = 0;

    logic [7:0] rd_buf [0:7];
    logic [7:0] wr_buf [0:7];

    assign sda_line = sda_m & ~sda_oe_o;

    always_comb begin
        tx_empty_i = (tx_tail == tx_head);
        tx_count_i = 16'(tx_tail - tx_head) + bias;
        tx_data_i  = txq[tx_head[5:0]];
    end

    always @(posedge clk) begin
        if (tx_pop_o) tx_head <= tx_head + 1;
        if (rx_push_o) begin
            rxq[rx_n[5:0]] <= rx_data_o;
            rx_n <= rx_n + 1;
        end
    end

    i2c_stream_target i_i2c_stream_target (
        .clk            (clk),
        .rst_n          (rst_n),
        .scl_i          (scl_m),
        .sda_i          (sda_line),
        .sda_oe_o       (sda_oe_o),
        .dev_addr_cfg_i (dev_cfg),
        .tx_count_i     (tx_count_i),
        .tx_empty_i     (tx_empty_i),
        .tx_data_i      (tx_data_i),
        .tx_pop_o       (tx_pop_o),
        .rx_data_o      (rx_data_o),
        .rx_push_o      (rx_push_o)
    );

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tx_put(input logic [7:0] b);
        txq[tx_tail[5:0]] = b;
        tx_tail = tx_tail + 1;
    endtask

    task automatic bit_out(input logic b);
        sda_m = b; #50; scl_m = 1'b1; #100; scl_m = 1'b0; #50;
    endtask

    task automatic bit_in(output logic b);
        sda_m = 1'b1; #50; scl_m = 1'b1; #50; b = sda_line; #50; scl_m = 1'b0; #50;
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; #50; scl_m = 1'b1; #50; sda_m = 1'b0; #50; scl_m = 1'b0; #50;
    endtask

    task automatic i2c_stop();
        sda_m = 1'b0; #50; scl_m = 1'b1; #50; sda_m = 1'b1; #100;
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        logic x;
        for (int i = 7; i >= 0; i--) bit_out(b[i]);
        bit_in(x);
        ack = ~x;
    endtask

    task automatic get_byte(input logic last, output logic [7:0] b);
        logic x;
        for (int i = 7; i >= 0; i--) begin
            bit_in(x);
            b[i] = x;
        end
        bit_out(last);
    endtask

    task automatic rand_read(input logic [7:0] reg_a, input int n);
        logic a1, a2, a3;
        logic [7:0] v;
        i2c_start();
        put_byte({dev7, 1'b0}, a1);
        put_byte(reg_a, a2);
        i2c_start();
        put_byte({dev7, 1'b1}, a3);
        for (int k = 0; k < n; k++) begin
            get_byte(k == n - 1, v);
            rd_buf[k] = v;
        end
        i2c_stop();
        check("R2 acks in random read", {13'b0, a1, a2, a3}, 16'h0007);
    endtask

    task automatic cur_read(input int n);
        logic a1;
        logic [7:0] v;
        i2c_start();
        put_byte({dev7, 1'b1}, a1);
        for (int k = 0; k < n; k++) begin
            get_byte(k == n - 1, v);
            rd_buf[k] = v;
        end
        i2c_stop();
        check("R2 ack in current read", {15'b0, a1}, 16'h0001);
    endtask

    task automatic wr_txn(input int n, input logic with_stop);
        logic a;
        int acks;
        acks = 0;
        i2c_start();
        put_byte({dev7, 1'b0}, a);
        if (a) acks++;
        for (int k = 0; k < n; k++) begin
            put_byte(wr_buf[k], a);
            if (a) acks++;
        end
        if (with_stop) i2c_stop();
        else i2c_start();
        #100;
        check("R8 every write byte acknowledged", 16'(acks), 16'(n + 1));
    endtask

    function automatic logic [7:0] exp_at(input int a);
        if (a < 253) return 8'h00;
        if (a == 253) return 8'h12;
        if (a == 254) return 8'h34;
        return 8'hFF;
    endfunction

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        nchk++;
        nerr++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

    initial begin : main
        int rx0;
        logic ack;
        #100;
        check("R1 sda released in reset", {15'b0, sda_oe_o}, 16'h0);
        rst_n = 1'b1;
        #100;
        check("R1 sda released after reset", {15'b0, sda_oe_o}, 16'h0);
        check("R1 no pop or push after reset", {14'b0, tx_pop_o, rx_push_o}, 16'h0);

        // R1 / R6: default pointer 0xFF, empty queue
        cur_read(1);
        check("R1 default read on empty queue", 16'(rd_buf[0]), 16'h00FF);
        cur_read(2);
        check("R6 saturated pointer byte0", 16'(rd_buf[0]), 16'h00FF);
        check("R6 saturated pointer byte1", 16'(rd_buf[1]), 16'h00FF);

        // R3 / R9: streaming of queue bytes
        for (int i = 0; i < 5; i++) tx_put(8'hA0 + 8'(i));
        cur_read(3);
        for (int i = 0; i < 3; i++) check("R3 stream byte", 16'(rd_buf[i]), 16'(8'hA0 + 8'(i)));
        check("R9 no extra pop after host NACK", 16'(tx_tail - tx_head), 16'd2);
        cur_read(3);
        check("R3 stream byte 3", 16'(rd_buf[0]), 16'h00A3);
        check("R3 stream byte 4", 16'(rd_buf[1]), 16'h00A4);
        check("R3 empty returns 0xFF", 16'(rd_buf[2]), 16'h00FF);
        check("R3 queue drained", 16'(tx_tail - tx_head), 16'd0);

        // R2: mismatching address ignored
        rx0 = rx_n;
        i2c_start();
        put_byte({7'h42, 1'b0}, ack);
        check("R2 foreign address not acked", {15'b0, ack}, 16'h0);
        put_byte(8'hFD, ack);
        put_byte(8'h11, ack);
        i2c_stop();
        check("R2 foreign write pushes nothing", 16'(rx_n - rx0), 16'd0);
        cur_read(1);
        check("R2 foreign write left pointer", 16'(rd_buf[0]), 16'h00FF);
        dev_cfg = 8'h87;
        cur_read(1);
        check("R2 direction bit of config ignored", 16'(rd_buf[0]), 16'h00FF);
        dev_cfg = 8'h86;

        // R5: count pair and snapshot
        bias = 16'h0300;
        tx_put(8'hB0);
        tx_put(8'hB1);
        rand_read(8'hFD, 2);
        check("R5 count high byte", 16'(rd_buf[0]), 16'h0003);
        check("R5 count low byte", 16'(rd_buf[1]), 16'h0002);
        rand_read(8'hFD, 1);
        check("R5 count high again", 16'(rd_buf[0]), 16'h0003);
        bias = 16'h0410;
        cur_read(1);
        check("R5 low byte is the snapshot", 16'(rd_buf[0]), 16'h0002);
        cur_read(1);
        check("R6 pointer stepped to 0xFF", 16'(rd_buf[0]), 16'h00B0);
        cur_read(1);
        check("R3 second queued byte", 16'(rd_buf[0]), 16'h00B1);

        // R7: single byte write sets pointer
        bias = 16'h5600;
        rx0 = rx_n;
        wr_buf[0] = 8'hFD;
        wr_txn(1, 1'b1);
        check("R7 single byte not pushed", 16'(rx_n - rx0), 16'd0);
        cur_read(2);
        check("R7 read starts at loaded pointer", 16'(rd_buf[0]), 16'h0056);
        check("R7 pointer then steps", 16'(rd_buf[1]), 16'h0000);

        // R8: multi byte writes
        wr_buf[0] = 8'hFD;
        wr_txn(1, 1'b1);
        rx0 = rx_n;
        wr_buf[0] = 8'h20; wr_buf[1] = 8'h31; wr_buf[2] = 8'h42;
        wr_txn(3, 1'b1);
        check("R8 three bytes pushed", 16'(rx_n - rx0), 16'd3);
        for (int i = 0; i < 3; i++) check("R8 pushed byte order", 16'(rxq[6'(rx0 + i)]), 16'(wr_buf[i]));
        cur_read(1);
        check("R8 pointer unchanged by data write", 16'(rd_buf[0]), 16'h0056);
        rx0 = rx_n;
        wr_buf[0] = 8'h7E; wr_buf[1] = 8'h81;
        wr_txn(2, 1'b1);
        check("R8 two byte write pushes two", 16'(rx_n - rx0), 16'd2);
        check("R8 two byte write first", 16'(rxq[6'(rx0)]), 16'h007E);
        check("R8 two byte write second", 16'(rxq[6'(rx0 + 1)]), 16'h0081);
        rx0 = rx_n;
        wr_buf[0] = 8'h99; wr_buf[1] = 8'hAA;
        wr_txn(2, 1'b0);
        i2c_stop();
        check("R8 write ended by repeated START", 16'(rx_n - rx0), 16'd2);
        check("R8 last byte flushed at START", 16'(rxq[6'(rx0 + 1)]), 16'h00AA);

        // R4: reserved reads have no side effect
        tx_put(8'hC0);
        rand_read(8'h05, 2);
        check("R4 reserved byte0", 16'(rd_buf[0]), 16'h0000);
        check("R4 reserved byte1", 16'(rd_buf[1]), 16'h0000);
        check("R4 no pop on reserved read", 16'(tx_tail - tx_head), 16'd1);
        rand_read(8'hFF, 1);
        check("R4 queue head intact", 16'(rd_buf[0]), 16'h00C0);

        // R4 / R5 / R6: sweep of start addresses
        bias = 16'h1234;
        rand_read(8'hFD, 1);
        for (int p = 0; p < 256; p++) begin
            if ((p % 16 == 0) || (p >= 248)) begin
                rand_read(8'(p), 3);
                for (int k = 0; k < 3; k++) begin
                    int a;
                    a = (p + k > 255) ? 255 : p + k;
                    check("R6 sweep byte", 16'(rd_buf[k]), 16'(exp_at(a)));
                end
            end
        end

        // R2: programmed address
        dev_cfg = 8'hA8;
        i2c_start();
        put_byte({7'h43, 1'b1}, ack);
        i2c_stop();
        check("R2 old address refused", {15'b0, ack}, 16'h0);
        dev7 = 7'h54;
        tx_put(8'h5A);
        cur_read(1);
        check("R2 new address served", 16'(rd_buf[0]), 16'h005A);

        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule